// File: doc/BRIEF.md
# Adaptive Residue-Nonlinearity and Gain Corrector

This block post-processes the raw codes of a converter back end. Each raw code is re-centred on mid-scale. An error term is added to it: a computed cubic shape of the code, scaled by the coefficient p2. The sum is then scaled by the gain coefficient p1. The result is rounded, returned to an offset-binary code and clamped to the code range. The corrected code leaves the block two clock cycles after the raw code enters.

Two coupled adaptive loops keep the coefficients tuned. Elsewhere, two residue distances are estimated: a centre distance H1 and a boundary distance H2. The p2 loop drives H1 towards H2, which cancels amplifier bending. The p1 loop drives H2 towards a fixed ideal distance, which fixes gain. Both loops settle when both distances equal half a transition height.

Step sizes are powers of two and are given as right-shift amounts. Small steps give low coefficient jitter; large steps give fast tracking. A sign-only mode moves each coefficient by a single LSB per update. Updates are suppressed while the distance estimator reports a flat histogram.

Top module: `resid_lms_corrector`

## Requirements
- R1: While rst is high, and in the first cycle after it, out_vld is 0, p1_coef is 256 (1.0 with 8 fraction bits) and p2_coef is 0.
- R2: out_vld is high exactly two rising edges after in_vld is sampled high, and low otherwise.
- R3: With x = raw_code − 128 and lut = floor(x³ / 16384), the error term is err = floor((lut·p2 + 128) / 256), and y = x + err.
- R4: The gain stage gives z = floor((y·p1 + 128) / 256), and out_code = z + 128.
- R5: out_code is clamped to the range 0 to 255.
- R6: An update adds floor((h1_dist − h2_dist) / 2^mu2_sh) to p2, visible one cycle after the update edge.
- R7: The same update adds floor((64 − h2_dist) / 2^mu1_sh) to p1. The ideal distance is 64.
- R8: An update happens only when h1_vld and h2_vld are both high and flat_warn is low. Otherwise both coefficients hold.
- R9: With sign_mode high, each coefficient moves by the sign of its difference: +1, −1 or 0.
- R10: Both coefficients saturate to the range −2048 to 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Raw code valid |
| raw_code | input | 8 | Raw back-end code, offset binary |
| h1_dist | input | 10 | Centre distance estimate |
| h1_vld | input | 1 | Centre estimate strobe |
| h2_dist | input | 10 | Boundary distance estimate |
| h2_vld | input | 1 | Boundary estimate strobe |
| flat_warn | input | 1 | Flat-histogram warning, blocks updates |
| sign_mode | input | 1 | 1: sign-only steps, 0: shifted-difference steps |
| mu1_sh | input | 4 | Right shift giving the gain-loop step size |
| mu2_sh | input | 4 | Right shift giving the nonlinearity-loop step size |
| out_vld | output | 1 | Corrected code valid |
| out_code | output | 8 | Corrected code |
| p1_coef | output | 12 | Gain coefficient, signed, 8 fraction bits |
| p2_coef | output | 12 | Nonlinearity coefficient, signed, 8 fraction bits |

## Verification
Corrected codes are due two rising edges after the raw code is presented. The bench streams every code from 0 to 255 back to back. At each falling edge it compares the output with the arithmetic result for the code driven two falling edges earlier. A coefficient update takes effect at the next rising edge, so the bench reads both coefficients at the following falling edge and compares them with a running model. It holds the coefficients fixed during each sweep, so the two pipeline stages never see different values.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int CODE_W  = 8;   // raw and corrected code width
  localparam int COEF_W  = 12;  // signed coefficient width
  localparam int FRAC_W  = 8;   // fraction bits of both coefficients
  localparam int DIST_W  = 10;  // distance estimate width
  localparam int SHIFT_W = 4;   // step-size shift width
  localparam int H_IDEAL = 64;  // target boundary distance
endpackage

// File: rtl/rlc_coef_loop.sv
// One saturating adaptive coefficient register (shared by both loops).
module rlc_coef_loop #(
  parameter int CWC     = 12,
  parameter int DW      = 11,
  parameter int SHW     = 4,
  parameter int RST_VAL = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  sgn,
  input  logic signed [DW-1:0]  diff,
  input  logic [SHW-1:0]        sh,
  output logic signed [CWC-1:0] q
);
  localparam logic signed [DW-1:0]  STEP_P = DW'(1);
  localparam logic signed [DW-1:0]  STEP_N = -DW'(1);
  localparam logic signed [CWC:0]   HI     = (CWC+1)'(2**(CWC-1) - 1);
  localparam logic signed [CWC:0]   LO     = -(CWC+1)'(2**(CWC-1));

  logic signed [DW-1:0] stp;
  logic signed [CWC:0]  sum;

  always_comb begin
    if (sgn) begin
      if (diff > 0)      stp = STEP_P;
      else if (diff < 0) stp = STEP_N;
      else               stp = '0;
    end else begin
      stp = diff >>> sh;
    end
    sum = (CWC+1)'(q) + (CWC+1)'(stp);
  end

  always_ff @(posedge clk) begin
    if (rst)             q <= CWC'(RST_VAL);
    else if (en) begin
      if (sum > HI)      q <= HI[CWC-1:0];
      else if (sum < LO) q <= LO[CWC-1:0];
      else               q <= sum[CWC-1:0];
    end
  end

  // sign-only steps move by at most one LSB
  assert_unit_step_R9: assert property (@(posedge clk) disable iff (rst)
    (en && sgn) |=> (q == $past(q) || q == $past(q) + CWC'(1) || q == $past(q) - CWC'(1)));
endmodule

// File: rtl/rlc_corr_pipe.sv
// Two-stage correction datapath: cubic error term, then gain and clamp.
module rlc_corr_pipe #(
  parameter int CW = 8,
  parameter int CF = 12,
  parameter int FB = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [CW-1:0]        code,
  input  logic signed [CF-1:0] p1,
  input  logic signed [CF-1:0] p2,
  output logic                 out_vld,
  output logic [CW-1:0]        out_code
);
  localparam int PW  = CW + CF;       // lut * p2 product width
  localparam int YW  = PW - FB + 1;   // corrected centred value width
  localparam int GW  = YW + CF;       // gain product width
  localparam int X3W = 3 * CW;
  localparam logic signed [PW-1:0] RND_P = PW'(2**(FB-1));
  localparam logic signed [GW-1:0] RND_G = GW'(2**(FB-1));
  localparam logic signed [GW-1:0] MID   = GW'(2**(CW-1));
  localparam logic signed [GW-1:0] TOP   = GW'(2**CW - 1);

  logic signed [CW-1:0]  x;
  logic signed [X3W-1:0] x3;
  logic signed [CW-1:0]  lut;
  logic signed [PW-1:0]  pr;
  logic signed [YW-1:0]  y_n;
  logic signed [YW-1:0]  y_q;
  logic                  v1_q;
  logic signed [GW-1:0]  zs;

  // stage 1: centred code, computed cubic shape, scaled error term
  always_comb begin
    x   = $signed({~code[CW-1], code[CW-2:0]});
    x3  = x * x * x;
    lut = CW'(x3 >>> (2 * (CW - 1)));
    pr  = lut * p2 + RND_P;
    y_n = YW'(pr >>> FB) + YW'(x);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      y_q  <= '0;
    end else begin
      v1_q <= in_vld;
      y_q  <= y_n;
    end
  end

  // stage 2: gain, rounding, return to offset binary, clamp
  always_comb zs = ((y_q * p1 + RND_G) >>> FB) + MID;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_code <= '0;
    end else begin
      out_vld <= v1_q;
      if (zs < 0)        out_code <= '0;
      else if (zs > TOP) out_code <= '1;
      else               out_code <= CW'(zs);
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld, 2));
endmodule

// File: rtl/resid_lms_corrector.sv
module resid_lms_corrector
  import rlc_pkg::*;
#(
  parameter int CW  = CODE_W,
  parameter int CF  = COEF_W,
  parameter int FB  = FRAC_W,
  parameter int HW  = DIST_W,
  parameter int SHW = SHIFT_W,
  parameter int HID = H_IDEAL
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [CW-1:0]        raw_code,
  input  logic [HW-1:0]        h1_dist,
  input  logic                 h1_vld,
  input  logic [HW-1:0]        h2_dist,
  input  logic                 h2_vld,
  input  logic                 flat_warn,
  input  logic                 sign_mode,
  input  logic [SHW-1:0]       mu1_sh,
  input  logic [SHW-1:0]       mu2_sh,
  output logic                 out_vld,
  output logic [CW-1:0]        out_code,
  output logic signed [CF-1:0] p1_coef,
  output logic signed [CF-1:0] p2_coef
);
  localparam int DW = HW + 1;
  localparam logic signed [DW-1:0] HID_S = DW'(HID);

  logic                 upd;
  logic signed [DW-1:0] d_nl;
  logic signed [DW-1:0] d_gain;

  always_comb begin
    upd    = h1_vld && h2_vld && !flat_warn;
    d_nl   = $signed({1'b0, h1_dist}) - $signed({1'b0, h2_dist});
    d_gain = HID_S - $signed({1'b0, h2_dist});
  end

  rlc_coef_loop #(.CWC(CF), .DW(DW), .SHW(SHW), .RST_VAL(0)) u_p2 (
    .clk(clk), .rst(rst), .en(upd), .sgn(sign_mode),
    .diff(d_nl), .sh(mu2_sh), .q(p2_coef));

  rlc_coef_loop #(.CWC(CF), .DW(DW), .SHW(SHW), .RST_VAL(2**FB)) u_p1 (
    .clk(clk), .rst(rst), .en(upd), .sgn(sign_mode),
    .diff(d_gain), .sh(mu1_sh), .q(p1_coef));

  rlc_corr_pipe #(.CW(CW), .CF(CF), .FB(FB)) u_pipe (
    .clk(clk), .rst(rst), .in_vld(in_vld), .code(raw_code),
    .p1(p1_coef), .p2(p2_coef), .out_vld(out_vld), .out_code(out_code));

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (p1_coef == CF'(2**FB) && p2_coef == '0 && !out_vld));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!(h1_vld && h2_vld) || flat_warn) |=> ($stable(p1_coef) && $stable(p2_coef)));
endmodule

// File: tb/sim_resid_lms_corrector.sv
`timescale 1ns/1ps
module sim_resid_lms_corrector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [7:0] raw_code = '0;
  logic [9:0] h1_dist = '0, h2_dist = '0;
  logic h1_vld = 1'b0, h2_vld = 1'b0, flat_warn = 1'b0, sign_mode = 1'b0;
  logic [3:0] mu1_sh = '0, mu2_sh = '0;
  logic out_vld;
  logic [7:0] out_code;
  logic signed [11:0] p1_coef, p2_coef;

  int checks = 0;
  int errors = 0;
  int m_p1 = 256;
  int m_p2 = 0;

  always #4 clk = ~clk;

  resid_lms_corrector u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .raw_code(raw_code),
    .h1_dist(h1_dist), .h1_vld(h1_vld), .h2_dist(h2_dist), .h2_vld(h2_vld),
    .flat_warn(flat_warn), .sign_mode(sign_mode), .mu1_sh(mu1_sh), .mu2_sh(mu2_sh),
    .out_vld(out_vld), .out_code(out_code), .p1_coef(p1_coef), .p2_coef(p2_coef));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp_coef(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int step_of(input int d, input int sh, input bit sm);
    if (sm) return (d > 0) ? 1 : ((d < 0) ? -1 : 0);
    return d >>> sh;
  endfunction

  function automatic int exp_out(input int c);
    int x, lut, err, y, z, o;
    x   = c - 128;
    lut = (x * x * x) >>> 14;
    err = (lut * m_p2 + 128) >>> 8;
    y   = x + err;
    z   = (y * m_p1 + 128) >>> 8;
    o   = z + 128;
    if (o < 0) o = 0;
    if (o > 255) o = 255;
    return o;
  endfunction

  // apply one estimate pair for one cycle, then compare coefficients
  task automatic update(input int h1, input int h2, input bit v1, input bit v2,
                        input bit fw, input bit sm, input int s1, input int s2,
                        input string req);
    @(negedge clk);
    h1_dist = 10'(h1); h2_dist = 10'(h2); h1_vld = v1; h2_vld = v2;
    flat_warn = fw; sign_mode = sm; mu1_sh = 4'(s1); mu2_sh = 4'(s2);
    if (v1 && v2 && !fw) begin
      m_p2 = clamp_coef(m_p2 + step_of(h1 - h2, s2, sm));
      m_p1 = clamp_coef(m_p1 + step_of(64 - h2, s1, sm));
    end
    @(negedge clk);
    h1_vld = 1'b0; h2_vld = 1'b0; flat_warn = 1'b0; sign_mode = 1'b0;
    check({req, " p2"}, int'(p2_coef), m_p2);
    check({req, " p1"}, int'(p1_coef), m_p1);
  endtask

  // stream all codes back to back; each result is due two edges later
  task automatic sweep(input string req);
    int hist [0:257];
    for (int i = 0; i < 258; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check({req, " R2 valid"}, int'(out_vld), 1);
        check(req, int'(out_code), exp_out(hist[i-2]));
      end
      hist[i] = i;
      in_vld   = (i < 256);
      raw_code = 8'(i);
    end
    in_vld = 1'b0;
    @(negedge clk);
    check({req, " R2 drain"}, int'(out_vld), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 p1", int'(p1_coef), 256);
    check("R1 p2", int'(p2_coef), 0);
    check("R1 out_vld", int'(out_vld), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 p1 after release", int'(p1_coef), 256);

    // R2: a single pulse appears exactly two edges later
    in_vld = 1'b1; raw_code = 8'd200;
    @(negedge clk);
    in_vld = 1'b0;
    check("R2 edge1", int'(out_vld), 0);
    @(negedge clk);
    check("R2 edge2", int'(out_vld), 1);
    check("R2 code", int'(out_code), 200);
    @(negedge clk);
    check("R2 edge3", int'(out_vld), 0);

    // R3/R4 identity with unit gain and zero error term
    sweep("R3 R4 identity");

    // R6/R7 updates, positive and negative, with shifts
    update(300, 64, 1, 1, 0, 0, 0, 0, "R6 R7 p2 up");
    update(40, 40, 1, 1, 0, 0, 2, 5, "R7 p1 up");
    update(10, 90, 1, 1, 0, 0, 1, 3, "R6 R7 negative floor");
    sweep("R3 R4 cubic error");

    // R8: blocked updates leave coefficients alone
    update(900, 0, 1, 0, 0, 0, 0, 0, "R8 h2 strobe low");
    update(900, 0, 0, 1, 0, 0, 0, 0, "R8 h1 strobe low");
    update(900, 0, 1, 1, 1, 0, 0, 0, "R8 flat warning");

    // R9: sign-only steps
    update(5, 900, 1, 1, 0, 1, 0, 0, "R9 down");
    update(64, 64, 1, 1, 0, 1, 0, 0, "R9 zero");
    update(900, 5, 1, 1, 0, 1, 0, 0, "R9 up");

    // larger gain so the top of the range clamps
    update(0, 0, 1, 1, 0, 0, 0, 9, "R7 gain raise");
    update(0, 0, 1, 1, 0, 0, 0, 9, "R7 gain raise");
    sweep("R5 clamp high");

    // R10: saturation of both coefficients
    for (int k = 0; k < 4; k++) update(1023, 0, 1, 1, 0, 0, 4, 0, "R10 p2 high");
    for (int k = 0; k < 40; k++) update(0, 0, 1, 1, 0, 0, 0, 9, "R10 p1 high");
    sweep("R5 saturated coefficients");
    for (int k = 0; k < 6; k++) update(0, 1023, 1, 1, 0, 0, 0, 0, "R10 low");
    sweep("R5 clamp negative gain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule